// File: doc/BRIEF.md
# Two-Cell-Per-Bit Boundary Register with Signature, Pattern and Count Modes

This block is the boundary register of a two-bus transceiver under test. Each bit position owns two scan cells: one on the A bus, one on the B bus. A value can therefore be captured from, or forced onto, either bus on its own. An external test access port controller supplies the capture, shift, update and run strobes and a decoded instruction. Serial data enters at `tdi` and leaves at `tdo`. Every action happens on the rising edge of the test clock, except `tdo`, which changes on the falling edge.

When no test instruction is active, the pin outputs carry the functional values from the transceiver core. Capture and shift can still take snapshots of the pins without disturbing them. Under a test instruction the update latches drive both buses.

The same cells also support three self-test modes, each of which advances once per run strobe:
- **Signature:** the A cells compress the A-pin inputs.
- **Pattern:** the B cells step a maximal-length sequence onto the B pins.
- **Signature with count:** the A side compresses while the B side counts upward, to sequence memory addresses.

Top module: `dual_bsr`

## Requirements
- R1: Each shift strobe moves the chain one place on the rising edge, in the order tdi → A cell W-1 … A cell 0 → B cell W-1 … B cell 0. `tdo` presents B cell 0 and changes only on the falling edge.
- R2: A capture strobe loads the A cells from `a_pin_in` and the B cells from `b_pin_in` in the same edge, bit for bit and independently.
- R3: Only an update strobe, or a run strobe in a pattern or count mode, changes the update latches. The driven pins stay stable while shifting.
- R4: The instruction code is 0 = functional, 1 = sample, 2 = force, 3 = signature, 4 = pattern, 5 = signature with count. Under codes 0 and 1 the pins carry `a_func` and `b_func`, and a capture does not alter them.
- R5: Under codes 2 to 5 the pins carry the update latches: `a_pin_out` carries the A latches and `b_pin_out` carries the B latches.
- R6: In codes 3 and 5 a run strobe replaces the A cells with step(A) XOR `a_pin_in`. Here step(x) = (x shifted left by one) XOR (taps if bit W-1 of x is set). For W = 4 the taps value is 4'h9; for W = 8 it is 8'h71.
- R7: In code 4 a run strobe replaces both the B cells and the B latches with step(B). From any nonzero seed the sequence returns to the seed after exactly 2^W-1 steps.
- R8: In code 5 a run strobe replaces both the B cells and the B latches with B+1, wrapping from all ones to zero.
- R9: A synchronous active-low reset clears every cell, every latch and `tdo`.
- R10: A run strobe under codes 0, 1 or 2 leaves the cells unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling edge |
| shift_en | input | 1 | Shift strobe |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe |
| run_en | input | 1 | Run-test strobe for self-test modes |
| instr | input | 3 | Decoded instruction code |
| a_pin_in | input | W | Values seen at the A pins |
| b_pin_in | input | W | Values seen at the B pins |
| a_func | input | W | Functional value for the A pins |
| b_func | input | W | Functional value for the B pins |
| a_pin_out | output | W | Value driven onto the A pins |
| b_pin_out | output | W | Value driven onto the B pins |

## Verification
The assertions take for granted that the controller raises at most one of the shift, capture, update and run strobes per cycle. They also assume that the instruction changes only between operations, so the pin-stability property compares like with like. The bench raises each strobe on its own for one cycle, and it changes the instruction only while all strobes are low. Seeds for the pattern mode are loaded nonzero, because an all-zero seed is a fixed point that the period check would not cover.

// File: rtl/dual_bsr_pkg.sv
// Package: instruction codes and sequence-generator taps shared by the
// dual-cell boundary register. Assumes widths 3..8 or 16 for the taps table.
package dual_bsr_pkg;

    typedef enum logic [2:0] {
        BI_FUNC    = 3'd0,
        BI_SAMPLE  = 3'd1,
        BI_FORCE   = 3'd2,
        BI_SIG     = 3'd3,
        BI_PATTERN = 3'd4,
        BI_SIGCNT  = 3'd5
    } bsr_instr_e;

    // Left-shifting feedback masks for maximal-length sequences.
    function automatic logic [31:0] seq_taps(input int w);
        case (w)
            3:       return 32'h5;
            4:       return 32'h9;
            5:       return 32'h9;
            6:       return 32'h21;
            7:       return 32'h41;
            8:       return 32'h71;
            16:      return 32'h6801;
            default: return 32'h0;
        endcase
    endfunction

    // True when the instruction hands the pins to the update latches.
    function automatic logic is_test(input bsr_instr_e i);
        return (i == BI_FORCE) || (i == BI_SIG) ||
               (i == BI_PATTERN) || (i == BI_SIGCNT);
    endfunction

endpackage

// File: rtl/dual_bsr_side.sv
// Module: one bus side of the boundary register (W scan cells plus W update
// latches). OUT_SIDE selects the self-test behaviour: 0 = signature over the
// pin inputs, 1 = pattern generator / counter that also refreshes the
// latches. Assumes the strobes are mutually exclusive.
module dual_bsr_side
    import dual_bsr_pkg::*;
#(
    parameter int W        = 8,
    parameter bit OUT_SIDE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         shift_en,
    input  logic         capture_en,
    input  logic         update_en,
    input  logic         run_en,
    input  bsr_instr_e   instr,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] cells,
    output logic [W-1:0] upd
);

    localparam logic [31:0]  TAPS_ALL = seq_taps(W);
    localparam logic [W-1:0] TAPS     = TAPS_ALL[W-1:0];

    logic [W-1:0] stepped;
    logic [W-1:0] run_next;
    logic         run_mode;
    logic         latch_follow;

    // One step of the left-shifting sequence generator.
    always_comb begin
        stepped = {cells[W-2:0], 1'b0} ^ (cells[W-1] ? TAPS : '0);
    end

    generate
        if (OUT_SIDE) begin : g_out
            // Output side: pattern generation or binary count.
            always_comb begin
                run_mode     = (instr == BI_PATTERN) || (instr == BI_SIGCNT);
                latch_follow = run_mode;
                run_next     = (instr == BI_SIGCNT) ? cells + W'(1) : stepped;
            end
        end else begin : g_in
            // Input side: signature compression of the pin values.
            always_comb begin
                run_mode     = (instr == BI_SIG) || (instr == BI_SIGCNT);
                latch_follow = 1'b0;
                run_next     = stepped ^ pin_in;
            end
        end
    endgenerate

    // Scan cells: shift, capture, or advance in a self-test mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cells <= '0;
        else if (shift_en)          cells <= {ser_in, cells[W-1:1]};
        else if (capture_en)        cells <= pin_in;
        else if (run_en && run_mode) cells <= run_next;
    end

    // Update latches: load on update, or track the generator while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                      upd <= '0;
        else if (update_en)              upd <= cells;
        else if (run_en && latch_follow) upd <= run_next;
    end

    assert_shift_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (cells[W-1] == $past(ser_in)) &&
                     (cells[W-2:0] == $past(cells[W-1:1])));

    assert_capture_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_en && !shift_en) |=> cells == $past(pin_in));

    assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_en && !(run_en && latch_follow)) |=> $stable(upd));

    assert_run_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !run_mode && !shift_en && !capture_en) |=> $stable(cells));

    generate
        if (OUT_SIDE) begin : g_out_chk
            assert_count_wraps_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (run_en && instr == BI_SIGCNT && !shift_en && !capture_en)
                |=> cells == $past(cells) + W'(1));

            assert_pattern_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (run_en && instr == BI_PATTERN && !shift_en && !capture_en && cells != '0)
                |=> cells != '0);
        end
    endgenerate

endmodule

// File: rtl/dual_bsr_tdo.sv
// Module: serial output stage. Retimes the last chain cell onto the falling
// edge so the receiving device samples it half a cycle later.
module dual_bsr_tdo (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic tdo
);

    // Falling-edge retiming of the chain end.
    always_ff @(negedge clk) begin
        if (!rst_n) tdo <= 1'b0;
        else        tdo <= ser_in;
    end

    assert_tdo_follows_R1: assert property (@(negedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tdo == $past(ser_in));

endmodule

// File: rtl/dual_bsr_pinmux.sv
// Module: pin output selection. The functional core drives the pins unless a
// test instruction is active, in which case the update latches drive them.
module dual_bsr_pinmux #(
    parameter int W = 8
) (
    input  logic         drive_test,
    input  logic [W-1:0] a_func,
    input  logic [W-1:0] b_func,
    input  logic [W-1:0] a_upd,
    input  logic [W-1:0] b_upd,
    output logic [W-1:0] a_pin_out,
    output logic [W-1:0] b_pin_out
);

    // Choose the source of each bus.
    always_comb begin
        a_pin_out = drive_test ? a_upd : a_func;
        b_pin_out = drive_test ? b_upd : b_func;
    end

endmodule

// File: rtl/dual_bsr.sv
// Module: dual-cell boundary register top. Chains the A side ahead of the
// B side between tdi and tdo and selects what the pins carry. Assumes an
// external controller issues one strobe per cycle and decodes the instruction.
module dual_bsr
    import dual_bsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         tdi,
    output logic         tdo,
    input  logic         shift_en,
    input  logic         capture_en,
    input  logic         update_en,
    input  logic         run_en,
    input  logic [2:0]   instr,
    input  logic [W-1:0] a_pin_in,
    input  logic [W-1:0] b_pin_in,
    input  logic [W-1:0] a_func,
    input  logic [W-1:0] b_func,
    output logic [W-1:0] a_pin_out,
    output logic [W-1:0] b_pin_out
);

    bsr_instr_e   op;
    logic         in_test;
    logic [W-1:0] a_cells, b_cells, a_upd, b_upd;

    // Decode the instruction code and the pin ownership.
    always_comb begin
        op      = bsr_instr_e'(instr);
        in_test = is_test(op);
    end

    dual_bsr_side #(.W(W), .OUT_SIDE(1'b0)) u_side_a (
        .clk(tck), .rst_n(rst_n), .ser_in(tdi),
        .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
        .run_en(run_en), .instr(op), .pin_in(a_pin_in),
        .cells(a_cells), .upd(a_upd)
    );

    dual_bsr_side #(.W(W), .OUT_SIDE(1'b1)) u_side_b (
        .clk(tck), .rst_n(rst_n), .ser_in(a_cells[0]),
        .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
        .run_en(run_en), .instr(op), .pin_in(b_pin_in),
        .cells(b_cells), .upd(b_upd)
    );

    dual_bsr_tdo u_tdo (
        .clk(tck), .rst_n(rst_n), .ser_in(b_cells[0]), .tdo(tdo)
    );

    dual_bsr_pinmux #(.W(W)) u_pinmux (
        .drive_test(in_test), .a_func(a_func), .b_func(b_func),
        .a_upd(a_upd), .b_upd(b_upd),
        .a_pin_out(a_pin_out), .b_pin_out(b_pin_out)
    );

    assert_pins_quiet_R5: assert property (@(posedge tck) disable iff (!rst_n)
        ($past(rst_n) && in_test && $stable(instr) &&
         !$past(update_en) && !$past(run_en))
        |-> ($stable(a_pin_out) && $stable(b_pin_out)));

    assert_b_chain_R1: assert property (@(posedge tck) disable iff (!rst_n)
        shift_en |=> b_cells[W-1] == $past(a_cells[0]));

endmodule

// File: tb/sim_dual_bsr.sv
module sim_dual_bsr;
    import dual_bsr_pkg::*;

    localparam int W = 4;
    localparam int N = 2 * W;

    logic         tck = 1'b0;
    logic         rst_n = 1'b0;
    logic         tdi = 1'b0;
    logic         tdo;
    logic         shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, run_en = 1'b0;
    logic [2:0]   instr = 3'd0;
    logic [W-1:0] a_pin_in = '0, b_pin_in = '0, a_func = '0, b_func = '0;
    logic [W-1:0] a_pin_out, b_pin_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 tck = ~tck;

    dual_bsr #(.W(W)) u0 (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .tdo(tdo),
        .shift_en(shift_en), .capture_en(capture_en), .update_en(update_en),
        .run_en(run_en), .instr(instr),
        .a_pin_in(a_pin_in), .b_pin_in(b_pin_in),
        .a_func(a_func), .b_func(b_func),
        .a_pin_out(a_pin_out), .b_pin_out(b_pin_out)
    );

    function automatic logic [W-1:0] step4(input logic [W-1:0] x);
        return {x[W-2:0], 1'b0} ^ (x[W-1] ? 4'h9 : 4'h0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit sh, input bit cap, input bit up, input bit run);
        shift_en = sh; capture_en = cap; update_en = up; run_en = run;
        @(posedge tck); #1;
        shift_en = 0; capture_en = 0; update_en = 0; run_en = 0;
    endtask

    // Shift v in LSB first, collect what leaves on tdo.
    task automatic shift_word(input logic [N-1:0] v, output logic [N-1:0] o);
        for (int i = 0; i < N; i++) begin
            @(negedge tck); #1;
            o[i] = tdo;
            tdi = v[i];
            shift_en = 1'b1;
            @(posedge tck); #1;
            shift_en = 1'b0;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] o, prev;
        logic [W-1:0] m, seed;
        instr = BI_FORCE;
        repeat (3) @(posedge tck);
        #1;
        // R9: reset clears latches, pins and tdo
        check(a_pin_out == 0 && b_pin_out == 0, "R9 pins", {a_pin_out, b_pin_out}, 0);
        check(tdo == 1'b0, "R9 tdo", tdo, 0);
        rst_n = 1'b1;

        // R1 R3 R5: every scan word; pins hold while shifting, then follow update
        prev = '0;
        for (int v = 0; v < 256; v++) begin
            shift_word(N'(v), o);
            check(o == prev, "R1 shifted-out word", o, prev);
            check({a_pin_out, b_pin_out} == prev, "R3 pins held during shift",
                  {a_pin_out, b_pin_out}, prev);
            pulse(0, 0, 1, 0);
            check({a_pin_out, b_pin_out} == N'(v), "R5 forced pins",
                  {a_pin_out, b_pin_out}, v);
            prev = N'(v);
        end

        // R4: functional and sample modes pass core values through
        for (int c = 0; c < 2; c++) begin
            instr = 3'(c);
            for (int f = 0; f < 256; f++) begin
                a_func = W'(f >> 4); b_func = W'(f);
                #1;
                check(a_pin_out == a_func && b_pin_out == b_func, "R4 functional path",
                      {a_pin_out, b_pin_out}, {a_func, b_func});
            end
        end
        a_pin_in = 4'h6; b_pin_in = 4'h9;
        pulse(0, 1, 0, 0);
        check(a_pin_out == a_func && b_pin_out == b_func, "R4 sample undisturbed",
              {a_pin_out, b_pin_out}, {a_func, b_func});

        // R2: capture both buses independently, read back through the chain
        instr = BI_SAMPLE;
        for (int a = 0; a < 16; a++) begin
            a_pin_in = W'(a);
            b_pin_in = W'(a * 7 + 3);
            pulse(0, 1, 0, 0);
            shift_word('0, o);
            check(o == {a_pin_in, b_pin_in}, "R2 capture", o, {a_pin_in, b_pin_in});
        end

        // R10: run strobe in non-generating modes leaves cells alone
        for (int c = 0; c < 3; c++) begin
            instr = 3'(c);
            shift_word(8'h5A, o);
            pulse(0, 0, 0, 1);
            pulse(0, 0, 0, 1);
            shift_word('0, o);
            check(o == 8'h5A, "R10 run ignored", o, 8'h5A);
        end

        // R6: signature compression for two seeds
        instr = BI_SIG;
        for (int s = 1; s < 3; s++) begin
            seed = W'(s * 5);
            shift_word({seed, 4'h0}, o);
            m = seed;
            for (int k = 0; k < 20; k++) begin
                a_pin_in = W'(k * 5 + s);
                pulse(0, 0, 0, 1);
                m = step4(m) ^ a_pin_in;
            end
            shift_word('0, o);
            check(o == {m, 4'h0}, "R6 signature", o, {m, 4'h0});
        end

        // R7: pattern generation, latch follows, full period
        instr = BI_PATTERN;
        shift_word(8'h01, o);
        pulse(0, 0, 1, 0);
        m = 4'h1;
        for (int k = 1; k <= 15; k++) begin
            pulse(0, 0, 0, 1);
            m = step4(m);
            check(b_pin_out == m, "R7 pattern word", b_pin_out, m);
            if (k < 15) check(b_pin_out != 4'h1, "R7 no early repeat", b_pin_out, 1);
        end
        check(b_pin_out == 4'h1, "R7 period 15", b_pin_out, 1);
        check(a_pin_out == 4'h0, "R7 A latch untouched", a_pin_out, 0);

        // R8: count with wrap on B, signature on A
        instr = BI_SIGCNT;
        shift_word({4'h3, 4'hD}, o);
        pulse(0, 0, 1, 0);
        m = 4'h3;
        for (int k = 0; k < 4; k++) begin
            a_pin_in = W'(k);
            pulse(0, 0, 0, 1);
            m = step4(m) ^ a_pin_in;
            check(b_pin_out == W'(4'hE + k), "R8 count", b_pin_out, W'(4'hE + k));
        end
        shift_word('0, o);
        check(o == {m, 4'h1}, "R8 combined state", o, {m, 4'h1});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule